// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block produces the strobes and the multiplexed address/data ports that an 8-bit controller with a 12-clock machine cycle uses to reach off-chip program and data memory. It counts oscillator clocks through each machine cycle. In ordinary cycles it emits two address-latch pulses and, when code comes from outside, two program-store read pulses. When the core asks for an external data move, the sequencer turns the following machine cycle into a data cycle. A data cycle keeps the first address-latch pulse, drops the second one and both program-store pulses, and drives a 6-clock read or write strobe.

At each machine-cycle boundary the block captures a context: the cycle kind, the program counter, the data pointer, the 8-bit register pointer, the high-port latch, the write byte and the internal/external code decision. All outputs for that cycle then come from this snapshot, so changes in the core's outputs during a cycle do not disturb the bus. Code is fetched externally when the external-access input is low, or when the program counter reaches the internal ROM size set by a parameter.

Top module: `ext_bus_seq`

## Requirements
- R1: While reset is held (from the first clock edge with rst_n low), ale=0, psen_n=1, rd_n=1, wr_n=1, lo_oe=0 and hi_out=FFh. The first clock edge with rst_n high starts a machine cycle at position 0, and that cycle uses the inputs present at that edge.
- R2: A machine cycle has 12 clock positions, numbered 0 to 11. In a fetch cycle, ale is high at positions 0, 1, 6 and 7 and low elsewhere. This gives two 2-clock pulses per cycle, one every 6 clocks.
- R3: In an externally fetched cycle, psen_n is low at positions 3–5 and 9–11 and high at every other position. In an internally fetched cycle, psen_n stays high for all 12 positions.
- R4: With int_rom_en=0 every fetch is external. With int_rom_en=1 a fetch is external only when pc ≥ ROM_KB·1024. With the default of 16, pc=3FFFh is internal and pc=4000h is external.
- R5: The cycle kind and all operands are sampled at the clock edge that ends position 11. xfer_req=1 at that edge makes the next cycle a data cycle, in which ale is high only at positions 0 and 1 and psen_n stays high. A request that is withdrawn before that edge has no effect.
- R6: In a data cycle, xfer_write=0 drives rd_n low at positions 5–10 and xfer_write=1 drives wr_n low at positions 5–10. rd_n and wr_n are never low together, and neither is low in a fetch cycle.
- R7: hi_out carries pc[15:8] in an external fetch cycle and dptr[15:8] in a data cycle with xfer_wide=1. In a data cycle with xfer_wide=0, and in an internal fetch cycle, it carries p2_latch.
- R8: lo_oe=1 with lo_out=pc[7:0] at positions 0–2 and 6–8 of an external fetch cycle. lo_oe=1 at positions 0–2 of a data cycle, with lo_out=dptr[7:0] when xfer_wide=1 and ri_addr when xfer_wide=0. lo_oe=1 with lo_out=wr_data at positions 5–10 of a write cycle. lo_oe=0 at all other times.
- R9: In a data cycle, ale is low at positions 2–4, so ale falls 3 clocks before rd_n or wr_n falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| int_rom_en | input | 1 | External-access level; 0 forces all code fetches off-chip |
| pc | input | 16 | Program counter |
| dptr | input | 16 | 16-bit data pointer |
| ri_addr | input | 8 | 8-bit register pointer for short data moves |
| p2_latch | input | 8 | High-port special-register latch |
| xfer_req | input | 1 | Request: make the next machine cycle an external data move |
| xfer_write | input | 1 | 1 = write move, 0 = read move |
| xfer_wide | input | 1 | 1 = 16-bit pointer, 0 = 8-bit register pointer |
| wr_data | input | 8 | Byte to drive during a write strobe |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Program-store read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| lo_out | output | 8 | Low address/data byte |
| lo_oe | output | 1 | Output enable for lo_out |
| hi_out | output | 8 | High address byte / port latch value |

## Verification
The main function is run through a vector table of single machine cycles. Internal and external fetches separate the program-store gating from the address-latch rate. The program counter pair 3FFFh/4000h, together with an all-ones counter with external access forced, pins down the ROM boundary. The four data-move combinations of read/write and wide/narrow pointer tell the high-byte source and the low-byte drive window apart. Directed cycles then show that a request withdrawn before the boundary edge leaves the next cycle a fetch, and that a reset in mid-cycle forces the idle levels and restarts at position 0 with the operands present at the release edge.

// File: rtl/ebs_pkg.sv
// Shared constants and the per-cycle context type of the external bus sequencer.
// Assumes a 12-clock machine cycle split into two equal halves.
package ebs_pkg;
    localparam int ADDR_W    = 16;
    localparam int BYTE_W    = 8;
    localparam int MC_CLOCKS = 12;
    localparam int HALF      = MC_CLOCKS / 2;
    localparam int POS_W     = $clog2(MC_CLOCKS);
    localparam int ALE_LEN   = 2;   // address-latch width, clocks
    localparam int ADDR_LEN  = 3;   // low address drive window, clocks
    localparam int PSEN_FROM = 3;   // program-store low from this half position
    localparam int XS_FROM   = 5;   // read/write strobe start position
    localparam int XS_LEN    = 6;   // read/write strobe width

    typedef struct packed {
        logic              data;
        logic              write;
        logic              wide;
        logic              ext;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] dptr;
        logic [BYTE_W-1:0] ri;
        logic [BYTE_W-1:0] p2;
        logic [BYTE_W-1:0] wdata;
    } bus_ctx_t;
endpackage

// File: rtl/ebs_phase_ctr.sv
// Machine-cycle position counter. Counts 0..MC_CLOCKS-1 and wraps.
// Reset parks the count on the last position so that the release edge
// both starts position 0 and loads the first cycle context.
module ebs_phase_ctr
    import ebs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    output logic [POS_W-1:0] pos,
    output logic             live,
    output logic             load
);
    localparam logic [POS_W-1:0] LAST = POS_W'(MC_CLOCKS - 1);

    // Advance the position and mark the sequencer active after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos  <= LAST;
            live <= 1'b0;
        end else begin
            pos  <= (pos == LAST) ? '0 : pos + 1'b1;
            live <= 1'b1;
        end
    end

    // Context load happens on the edge that ends the last position.
    assign load = rst_n && (pos == LAST);
endmodule

// File: rtl/ebs_cycle_ctx.sv
// Captures the cycle kind, operands and the internal/external code decision
// at each machine-cycle boundary. Assumes the core holds its outputs stable
// across the boundary edge. The port latch resets to all ones.
module ebs_cycle_ctx
    import ebs_pkg::*;
#(
    parameter int ROM_KB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              int_rom_en,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] dptr,
    input  logic [BYTE_W-1:0] ri_addr,
    input  logic [BYTE_W-1:0] p2_latch,
    input  logic              xfer_req,
    input  logic              xfer_write,
    input  logic              xfer_wide,
    input  logic [BYTE_W-1:0] wr_data,
    output bus_ctx_t          ctx
);
    localparam int              ROM_BYTES = ROM_KB * 1024;
    localparam logic [ADDR_W:0] ROM_LIM   = (ADDR_W + 1)'(ROM_BYTES);

    logic ext_now;

    // Code goes off-chip when forced or when the counter passes the ROM.
    always_comb ext_now = !int_rom_en || ({1'b0, pc} >= ROM_LIM);

    // Snapshot the context for the coming machine cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx    <= '0;
            ctx.p2 <= '1;
        end else if (load) begin
            ctx <= '{xfer_req, xfer_write, xfer_wide, ext_now,
                     pc, dptr, ri_addr, p2_latch, wr_data};
        end
    end
endmodule

// File: rtl/ebs_strobe_gen.sv
// Decodes the machine-cycle position and cycle kind into the bus strobes.
// Assumes pos counts 0..MC_CLOCKS-1; live gates every strobe to idle.
module ebs_strobe_gen
    import ebs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] pos,
    input  logic             live,
    input  logic             data,
    input  logic             write,
    input  logic             ext,
    output logic             ale,
    output logic             psen_n,
    output logic             rd_n,
    output logic             wr_n,
    output logic             addr_ph,
    output logic             wdata_ph
);
    localparam logic [POS_W-1:0] P_HALF  = POS_W'(HALF);
    localparam logic [POS_W-1:0] P_ALE   = POS_W'(ALE_LEN);
    localparam logic [POS_W-1:0] P_ADDR  = POS_W'(ADDR_LEN);
    localparam logic [POS_W-1:0] P_PSEN  = POS_W'(PSEN_FROM);
    localparam logic [POS_W-1:0] P_XS_LO = POS_W'(XS_FROM);
    localparam logic [POS_W-1:0] P_XS_HI = POS_W'(XS_FROM + XS_LEN);

    logic             second;
    logic [POS_W-1:0] hpos;
    logic             xs;

    // Position within the current half cycle.
    always_comb begin
        second = (pos >= P_HALF);
        hpos   = second ? pos - P_HALF : pos;
    end

    // Strobe decode; second-half latch and both store pulses drop in data cycles.
    always_comb begin
        xs       = data && (pos >= P_XS_LO) && (pos < P_XS_HI);
        ale      = live && (hpos < P_ALE) && (!second || !data);
        psen_n   = !(live && !data && ext && (hpos >= P_PSEN));
        rd_n     = !(live && xs && !write);
        wr_n     = !(live && xs && write);
        addr_ph  = live && (hpos < P_ADDR) && (!second || !data);
        wdata_ph = live && xs && write;
    end

    // Latch pulse lasts two clocks.
    assert_ale_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> $past(ale, 2));

    // Read and write strobes never overlap.
    assert_rd_wr_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // Read strobe is six clocks wide.
    assert_rd_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_n) |-> (!$past(rd_n, 6) && $past(rd_n, 7)));

    // Program-store stays idle while a data strobe is active.
    assert_psen_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> psen_n);

    // Latch falls three clocks ahead of a data strobe.
    assert_ale_lead_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_n) || $fell(wr_n)) |-> ($past(ale, 4) && !$past(ale, 3)));
endmodule

// File: rtl/ebs_port_mux.sv
// Selects the low address/data byte, its enable, and the high address byte
// from the captured cycle context and the phase windows.
module ebs_port_mux
    import ebs_pkg::*;
(
    input  bus_ctx_t          ctx,
    input  logic              addr_ph,
    input  logic              wdata_ph,
    output logic [BYTE_W-1:0] lo_out,
    output logic              lo_oe,
    output logic [BYTE_W-1:0] hi_out
);
    logic [BYTE_W-1:0] addr_lo;

    // High byte: pointer or counter high half, else the port latch.
    always_comb begin
        if (ctx.data)
            hi_out = ctx.wide ? ctx.dptr[ADDR_W-1:BYTE_W] : ctx.p2;
        else
            hi_out = ctx.ext ? ctx.pc[ADDR_W-1:BYTE_W] : ctx.p2;
    end

    // Low byte: address in its window, write data under the write strobe.
    always_comb begin
        if (ctx.data)
            addr_lo = ctx.wide ? ctx.dptr[BYTE_W-1:0] : ctx.ri;
        else
            addr_lo = ctx.pc[BYTE_W-1:0];
        lo_oe  = wdata_ph || (addr_ph && (ctx.data || ctx.ext));
        lo_out = wdata_ph ? ctx.wdata : (lo_oe ? addr_lo : '0);
    end
endmodule

// File: rtl/ext_bus_seq.sv
// External memory bus cycle sequencer top. Ties the position counter, the
// cycle context register, the strobe decoder and the port selector.
// Assumes the core holds its request and operands across each boundary edge.
module ext_bus_seq
    import ebs_pkg::*;
#(
    parameter int ROM_KB = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        int_rom_en,
    input  logic [15:0] pc,
    input  logic [15:0] dptr,
    input  logic [7:0]  ri_addr,
    input  logic [7:0]  p2_latch,
    input  logic        xfer_req,
    input  logic        xfer_write,
    input  logic        xfer_wide,
    input  logic [7:0]  wr_data,
    output logic        ale,
    output logic        psen_n,
    output logic        rd_n,
    output logic        wr_n,
    output logic [7:0]  lo_out,
    output logic        lo_oe,
    output logic [7:0]  hi_out
);
    logic [POS_W-1:0] pos;
    logic             live;
    logic             load;
    bus_ctx_t         ctx;
    logic             addr_ph;
    logic             wdata_ph;

    ebs_phase_ctr u_ctr (
        .clk (clk), .rst_n (rst_n), .pos (pos), .live (live), .load (load)
    );

    ebs_cycle_ctx #(.ROM_KB(ROM_KB)) u_ctx (
        .clk (clk), .rst_n (rst_n), .load (load), .int_rom_en (int_rom_en),
        .pc (pc), .dptr (dptr), .ri_addr (ri_addr), .p2_latch (p2_latch),
        .xfer_req (xfer_req), .xfer_write (xfer_write), .xfer_wide (xfer_wide),
        .wr_data (wr_data), .ctx (ctx)
    );

    ebs_strobe_gen u_strb (
        .clk (clk), .rst_n (rst_n), .pos (pos), .live (live),
        .data (ctx.data), .write (ctx.write), .ext (ctx.ext),
        .ale (ale), .psen_n (psen_n), .rd_n (rd_n), .wr_n (wr_n),
        .addr_ph (addr_ph), .wdata_ph (wdata_ph)
    );

    ebs_port_mux u_mux (
        .ctx (ctx), .addr_ph (addr_ph), .wdata_ph (wdata_ph),
        .lo_out (lo_out), .lo_oe (lo_oe), .hi_out (hi_out)
    );

    // Write strobe always has the low port driving.
    assert_wr_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> lo_oe);

    // Read strobe always has the low port released.
    assert_rd_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !lo_oe);
endmodule

// File: tb/tb_ext_bus_seq.sv
`timescale 1ns/1ps
module tb_ext_bus_seq;
    typedef struct packed {
        logic        int_en;
        logic [15:0] pc;
        logic        req;
        logic        wr;
        logic        wide;
        logic [15:0] dptr;
        logic [7:0]  ri;
        logic [7:0]  p2;
        logic [7:0]  wd;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 16'h0123, 1'b0, 1'b0, 1'b0, 16'h0000, 8'h00, 8'h5A, 8'h00}, // internal fetch
        '{1'b0, 16'h0123, 1'b0, 1'b0, 1'b0, 16'h0000, 8'h00, 8'h5A, 8'h00}, // forced external
        '{1'b1, 16'h3FFF, 1'b0, 1'b0, 1'b0, 16'h0000, 8'h00, 8'h99, 8'h00}, // last internal
        '{1'b1, 16'h4000, 1'b0, 1'b0, 1'b0, 16'h0000, 8'h00, 8'h99, 8'h00}, // first external
        '{1'b1, 16'h0200, 1'b1, 1'b0, 1'b1, 16'hA55A, 8'h11, 8'h22, 8'h33}, // read, wide
        '{1'b1, 16'h0200, 1'b1, 1'b1, 1'b0, 16'hBEEF, 8'h3C, 8'h81, 8'hE7}, // write, narrow
        '{1'b0, 16'h8000, 1'b1, 1'b1, 1'b1, 16'h1234, 8'h44, 8'h66, 8'h5A}, // write, wide
        '{1'b0, 16'h8000, 1'b1, 1'b0, 1'b0, 16'hCAFE, 8'h77, 8'h42, 8'h00}, // read, narrow
        '{1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b0, 16'h0000, 8'h00, 8'h18, 8'h00}  // top of space
    };
    localparam vec_t IDLE = '{1'b1, 16'h0100, 1'b0, 1'b0, 1'b0, 16'h0000, 8'h00, 8'hC3, 8'h00};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        int_rom_en, xfer_req, xfer_write, xfer_wide;
    logic [15:0] pc, dptr;
    logic [7:0]  ri_addr, p2_latch, wr_data;
    logic        ale, psen_n, rd_n, wr_n, lo_oe;
    logic [7:0]  lo_out, hi_out;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    ext_bus_seq dut (
        .clk (clk), .rst_n (rst_n), .int_rom_en (int_rom_en), .pc (pc),
        .dptr (dptr), .ri_addr (ri_addr), .p2_latch (p2_latch),
        .xfer_req (xfer_req), .xfer_write (xfer_write), .xfer_wide (xfer_wide),
        .wr_data (wr_data), .ale (ale), .psen_n (psen_n), .rd_n (rd_n),
        .wr_n (wr_n), .lo_out (lo_out), .lo_oe (lo_oe), .hi_out (hi_out)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        int_rom_en = v.int_en; pc = v.pc; xfer_req = v.req; xfer_write = v.wr;
        xfer_wide = v.wide; dptr = v.dptr; ri_addr = v.ri; p2_latch = v.p2;
        wr_data = v.wd;
    endtask

    // Expected outputs at position p of a cycle run with vector v.
    task automatic check_pos(input vec_t v, input int p);
        bit ext, e_ale, e_psen_n, e_rd_n, e_wr_n, e_oe;
        logic [7:0] e_hi, e_lo;
        ext      = !v.int_en || (v.pc >= 16'h4000);         // R4
        e_ale    = (p < 2) || (!v.req && (p == 6 || p == 7)); // R2, R5
        e_psen_n = !(!v.req && ext && ((p >= 3 && p <= 5) || p >= 9)); // R3
        e_rd_n   = !(v.req && !v.wr && p >= 5 && p <= 10);  // R6
        e_wr_n   = !(v.req && v.wr && p >= 5 && p <= 10);
        if (v.req) e_hi = v.wide ? v.dptr[15:8] : v.p2;     // R7
        else       e_hi = ext ? v.pc[15:8] : v.p2;
        e_oe = 1'b0; e_lo = 8'h00;                           // R8
        if (v.req) begin
            if (p <= 2) begin e_oe = 1'b1; e_lo = v.wide ? v.dptr[7:0] : v.ri; end
            else if (v.wr && p >= 5 && p <= 10) begin e_oe = 1'b1; e_lo = v.wd; end
        end else if (ext && (p <= 2 || (p >= 6 && p <= 8))) begin
            e_oe = 1'b1; e_lo = v.pc[7:0];
        end
        chk(ale == e_ale, v.req ? ((p >= 2 && p <= 4) ? "R9" : "R5") : "R2",
            $sformatf("ale pos %0d", p), 16'(ale), 16'(e_ale));
        chk(psen_n == e_psen_n, v.req ? "R5" : "R3",
            $sformatf("psen_n pos %0d", p), 16'(psen_n), 16'(e_psen_n));
        if (!v.req && p == 3)
            chk(psen_n == !ext, "R4", "fetch source", 16'(psen_n), 16'(!ext));
        chk(rd_n == e_rd_n, "R6", $sformatf("rd_n pos %0d", p), 16'(rd_n), 16'(e_rd_n));
        chk(wr_n == e_wr_n, "R6", $sformatf("wr_n pos %0d", p), 16'(wr_n), 16'(e_wr_n));
        chk(hi_out == e_hi, "R7", $sformatf("hi_out pos %0d", p), 16'(hi_out), 16'(e_hi));
        chk(lo_oe == e_oe, "R8", $sformatf("lo_oe pos %0d", p), 16'(lo_oe), 16'(e_oe));
        if (e_oe)
            chk(lo_out == e_lo, "R8", $sformatf("lo_out pos %0d", p), 16'(lo_out), 16'(e_lo));
    endtask

    task automatic check_reset_idle();
        chk(ale == 1'b0, "R1", "ale in reset", 16'(ale), 16'h0);
        chk(psen_n == 1'b1, "R1", "psen_n in reset", 16'(psen_n), 16'h1);
        chk(rd_n == 1'b1 && wr_n == 1'b1, "R1", "rd_n/wr_n in reset",
            16'({rd_n, wr_n}), 16'h3);
        chk(lo_oe == 1'b0, "R1", "lo_oe in reset", 16'(lo_oe), 16'h0);
        chk(hi_out == 8'hFF, "R1", "hi_out in reset", 16'(hi_out), 16'hFF);
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_err++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        apply(VECS[0]);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_reset_idle();                                  // R1
        rst_n = 1'b1;                                        // release edge loads VECS[0]

        // Table walk: one machine cycle per vector, next vector applied at pos 0.
        for (int i = 0; i < NV; i++) begin
            for (int p = 0; p < 12; p++) begin
                @(negedge clk);
                check_pos(VECS[i], p);
                if (p == 0) apply((i < NV - 1) ? VECS[i + 1] : IDLE);
            end
        end

        // R5: request pulse withdrawn before the boundary edge is ignored.
        for (int p = 0; p < 12; p++) begin
            @(negedge clk);
            check_pos(IDLE, p);
            if (p == 3) xfer_req = 1'b1;
            if (p == 6) xfer_req = 1'b0;
        end
        for (int p = 0; p < 12; p++) begin
            @(negedge clk);
            check_pos(IDLE, p);                              // still a fetch cycle (R5)
        end

        // R1: reset in mid-cycle, then restart at position 0 with a read loaded.
        for (int p = 0; p < 5; p++) begin
            @(negedge clk);
            check_pos(IDLE, p);
        end
        rst_n = 1'b0;
        apply(VECS[4]);
        @(negedge clk);
        check_reset_idle();
        @(negedge clk);
        check_reset_idle();
        rst_n = 1'b1;
        for (int p = 0; p < 12; p++) begin
            @(negedge clk);
            check_pos(VECS[4], p);                           // R1 restart, R6 read
            if (p == 0) apply(IDLE);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule